// File: doc/BRIEF.md
# Per-Bank Deferred Write Drain

This block sits beside the command arbiter of a DRAM channel controller and decides, separately for every bank, when a buffered write may begin its precharge/activate sequence. A bank's write is no longer held back just because reads to some other bank are still queued. It becomes a candidate as soon as its own bank has no reads pending and a write to it is ready.

Even then the write does not start at once. A per-bank hold-off counter must first reach a shared threshold. A read that lands in the bank during the roughly 22-cycle precharge plus activate window would cancel the write, so waiting lowers that risk. Any read arrival or cancellation for the bank restarts its wait.

Two global conditions override the per-bank logic, as in a conventional drain. If the whole read queue is empty, every ready write may start. If the write queue fills up to a programmable watermark, every ready write is released at once.

Top module: `wr_defer_drain`

## Requirements
- R1: While reset is high no bank receives start permission, and after reset every bank's wait counter is zero, so with a threshold of 1 the first eligible cycle gives no permission.
- R2: In per-bank mode a bank whose pending-read count (its RD_W-bit field at bit offset bank*RD_W of `bank_rd_pending`) is non-zero never receives permission, while other banks still proceed independently.
- R3: In per-bank mode a bank that is continuously eligible (write ready, zero pending reads, no arrival or cancel strobe) receives permission from exactly `cfg_wait_k` cycles after its first eligible cycle, and keeps it while eligible.
- R4: A read-arrival strobe for a bank removes its permission in that cycle and restarts its wait from zero.
- R5: A cancel strobe for a bank removes its permission in that cycle and restarts its wait from zero.
- R6: The wait counter saturates at its all-ones value (255 for 8 bits) and never wraps, so a threshold of 255 keeps permission asserted for as long as eligibility lasts.
- R7: A threshold of 0 gives permission in the first eligible cycle.
- R8: When `rq_empty` is high and the watermark is not reached, permission equals write-ready with the arrival strobe masked out, ignoring the wait counter and the pending counts.
- R9: When `wq_occupancy >= cfg_hi_mark`, permission equals write-ready for every bank, ignoring pending reads, strobes and the wait counter.
- R10: No bank ever receives permission without its write-ready input, and dropping write-ready restarts the bank's wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait_k | input | CNT_W | Hold-off threshold in cycles |
| cfg_hi_mark | input | OCC_W | Write-queue watermark forcing a drain |
| wq_occupancy | input | OCC_W | Current write-queue occupancy |
| rq_empty | input | 1 | Read queue of the channel holds no request |
| bank_wr_ready | input | NUM_BANKS | Per-bank write ready for precharge/activate |
| bank_rd_pending | input | NUM_BANKS*RD_W | Per-bank pending read counts, bank b at bits b*RD_W upward |
| bank_rd_arrive | input | NUM_BANKS | Per-bank read-arrival strobe |
| bank_wr_cancel | input | NUM_BANKS | Per-bank strobe: a started write was interrupted |
| bank_wr_start | output | NUM_BANKS | Per-bank permission to begin precharge/activate for the write |

## Verification
The bench builds the block with four banks, an 8-bit counter, 3-bit pending counts and a 5-bit occupancy. The 8-bit counter makes the saturation corner reachable: with the threshold at 255, a counter that wrapped would drop permission one cycle after granting it, and that drop shows at the output within a few hundred cycles. Four banks are enough to hold one bank back with pending reads, strobes or a missing ready while a neighbour counts, so interference between banks becomes visible. The 5-bit occupancy lets the watermark be set anywhere in its range for the forced-drain cases.

// File: rtl/wdd_pkg.sv
package wdd_pkg;

    // Global drain mode, highest priority first: forced, idle-read, per-bank.
    typedef enum logic [1:0] {
        DM_BANK  = 2'd0,
        DM_IDLE  = 2'd1,
        DM_FORCE = 2'd2
    } drain_mode_e;

    // Per-bank view handed to a bank timer.
    typedef struct packed {
        logic ready;     // write waiting for precharge/activate
        logic no_reads;  // pending read count is zero
        logic arrive;    // read arrived this cycle
        logic cancel;    // started write was interrupted this cycle
    } bank_in_t;

    function automatic logic bank_eligible(bank_in_t b);
        return b.ready && b.no_reads;
    endfunction

    function automatic logic bank_restart(bank_in_t b);
        return b.arrive || b.cancel || !bank_eligible(b);
    endfunction

endpackage

// File: rtl/wdd_mode_sel.sv
module wdd_mode_sel import wdd_pkg::*; #(
    parameter int OCC_W = 6
) (
    input  logic             rq_empty,
    input  logic [OCC_W-1:0] wq_occupancy,
    input  logic [OCC_W-1:0] hi_mark,
    output drain_mode_e      mode
);

    always_comb begin
        if (wq_occupancy >= hi_mark) begin
            mode = DM_FORCE;
        end else if (rq_empty) begin
            mode = DM_IDLE;
        end else begin
            mode = DM_BANK;
        end
    end

endmodule

// File: rtl/wdd_bank_timer.sv
module wdd_bank_timer import wdd_pkg::*; #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_in_t         bin,
    input  logic [CNT_W-1:0] wait_k,
    output logic             timer_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             restart;
    logic             elig;

    assign elig    = bank_eligible(bin);
    assign restart = bank_restart(bin);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign timer_done = !restart && (cnt >= wait_k);

    // R6: once at the top the counter stays there while the bank stays eligible
    a_r6_hold_at_max: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !restart) |=> (cnt == CNT_MAX));

    // R3: with a non-zero threshold the wait must have been running last cycle
    a_r3_needs_history: assert property (@(posedge clk) disable iff (rst)
        (timer_done && wait_k != '0) |-> $past(elig));

endmodule

// File: rtl/wr_defer_drain.sv
module wr_defer_drain import wdd_pkg::*; #(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 8,
    parameter int RD_W      = 5,
    parameter int OCC_W     = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          cfg_wait_k,
    input  logic [OCC_W-1:0]          cfg_hi_mark,
    input  logic [OCC_W-1:0]          wq_occupancy,
    input  logic                      rq_empty,
    input  logic [NUM_BANKS-1:0]      bank_wr_ready,
    input  logic [NUM_BANKS*RD_W-1:0] bank_rd_pending,
    input  logic [NUM_BANKS-1:0]      bank_rd_arrive,
    input  logic [NUM_BANKS-1:0]      bank_wr_cancel,
    output logic [NUM_BANKS-1:0]      bank_wr_start
);

    drain_mode_e mode;

    wdd_mode_sel #(.OCC_W(OCC_W)) u_mode (
        .rq_empty     (rq_empty),
        .wq_occupancy (wq_occupancy),
        .hi_mark      (cfg_hi_mark),
        .mode         (mode)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_in_t        bin;
        logic [RD_W-1:0] pend;
        logic            done;

        assign pend = bank_rd_pending[b*RD_W +: RD_W];

        always_comb begin
            bin.ready    = bank_wr_ready[b];
            bin.no_reads = (pend == '0);
            bin.arrive   = bank_rd_arrive[b];
            bin.cancel   = bank_wr_cancel[b];
        end

        wdd_bank_timer #(.CNT_W(CNT_W)) u_timer (
            .clk        (clk),
            .rst        (rst),
            .bin        (bin),
            .wait_k     (cfg_wait_k),
            .timer_done (done)
        );

        always_comb begin
            if (rst) begin
                bank_wr_start[b] = 1'b0;
            end else begin
                unique case (mode)
                    DM_FORCE: bank_wr_start[b] = bank_wr_ready[b];
                    DM_IDLE:  bank_wr_start[b] = bank_wr_ready[b] && !bank_rd_arrive[b];
                    default:  bank_wr_start[b] = done;
                endcase
            end
        end

        // R10: permission only with a ready write
        a_r10_needs_ready: assert property (@(posedge clk) disable iff (rst)
            bank_wr_start[b] |-> bank_wr_ready[b]);

        // R2: pending reads to this bank block it outside the global drains
        a_r2_pending_blocks: assert property (@(posedge clk) disable iff (rst)
            (!rq_empty && wq_occupancy < cfg_hi_mark && pend != '0) |-> !bank_wr_start[b]);

        // R4: an arrival last cycle leaves the wait at zero
        a_r4_arrive_restarts: assert property (@(posedge clk) disable iff (rst)
            ($past(bank_rd_arrive[b]) && !rq_empty && wq_occupancy < cfg_hi_mark
             && cfg_wait_k != '0) |-> !bank_wr_start[b]);

        // R5: a cancellation last cycle leaves the wait at zero
        a_r5_cancel_restarts: assert property (@(posedge clk) disable iff (rst)
            ($past(bank_wr_cancel[b]) && !rq_empty && wq_occupancy < cfg_hi_mark
             && cfg_wait_k != '0) |-> !bank_wr_start[b]);

        // R9: at the watermark permission follows ready
        a_r9_forced_follows_ready: assert property (@(posedge clk) disable iff (rst)
            (wq_occupancy >= cfg_hi_mark) |-> (bank_wr_start[b] == bank_wr_ready[b]));
    end

endmodule

// File: tb/wr_defer_drain_test.sv
`timescale 1ns/1ps
module wr_defer_drain_test;

    localparam int NB    = 4;
    localparam int CW    = 8;
    localparam int RW    = 3;
    localparam int OW    = 5;
    localparam int LIMIT = 200000;

    logic              clk = 1'b0;
    logic              rst;
    logic [CW-1:0]     k;
    logic [OW-1:0]     hi_mark;
    logic [OW-1:0]     occ;
    logic              rq_empty;
    logic [NB-1:0]     ready;
    logic [NB*RW-1:0]  pend;
    logic [NB-1:0]     arrive;
    logic [NB-1:0]     cancel;
    logic [NB-1:0]     start;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wr_defer_drain #(.NUM_BANKS(NB), .CNT_W(CW), .RD_W(RW), .OCC_W(OW)) uut (
        .clk             (clk),
        .rst             (rst),
        .cfg_wait_k      (k),
        .cfg_hi_mark     (hi_mark),
        .wq_occupancy    (occ),
        .rq_empty        (rq_empty),
        .bank_wr_ready   (ready),
        .bank_rd_pending (pend),
        .bank_rd_arrive  (arrive),
        .bank_wr_cancel  (cancel),
        .bank_wr_start   (start)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == LIMIT && !done) begin
            n_fail++;
            $display("FAIL watchdog R1..: run hung, actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [NB-1:0] exp);
        #1;
        n_chk++;
        if (start !== exp) begin
            n_fail++;
            $display("FAIL %s: bank_wr_start actual %b expected %b", req, start, exp);
        end
    endtask

    task automatic set_pend(input int b, input int v);
        pend[b*RW +: RW] = RW'(v);
    endtask

    task automatic clear_all();
        ready = '0; pend = '0; arrive = '0; cancel = '0;
        rq_empty = 1'b0; occ = '0; hi_mark = 5'd20;
        cyc(2);
    endtask

    task automatic t_reset();
        rst = 1'b1; k = 8'd1; hi_mark = 5'd20; occ = '0;
        rq_empty = 1'b1; ready = 4'b1111; pend = '0; arrive = '0; cancel = '0;
        cyc(3);
        chk("R1 in reset", 4'b0000);
        cyc(1);
        rst = 1'b0; rq_empty = 1'b0;
        chk("R1 first cycle after reset", 4'b0000);
        cyc(1);
        chk("R1 R3 after one cycle, k=1", 4'b1111);
    endtask

    task automatic t_threshold();
        clear_all();
        k = 8'd5;
        ready = 4'b0001;
        chk("R3 cycle 0", 4'b0000);
        for (int j = 1; j < 5; j++) begin
            cyc(1);
            chk("R3 before threshold", 4'b0000);
        end
        cyc(1);
        chk("R3 at threshold", 4'b0001);
        cyc(3);
        chk("R3 held while eligible", 4'b0001);
    endtask

    task automatic t_pending();
        clear_all();
        k = 8'd3;
        ready = 4'b0011;
        set_pend(1, 2);
        for (int j = 0; j < 3; j++) begin
            if (j > 0) cyc(1);
            chk("R2 both waiting", 4'b0000);
        end
        cyc(1);
        chk("R2 bank0 free, bank1 blocked by pending", 4'b0001);
        cyc(5);
        chk("R2 bank1 still blocked", 4'b0001);
        set_pend(1, 0);
        for (int j = 0; j < 3; j++) begin
            if (j > 0) cyc(1);
            chk("R2 bank1 counting after reads drained", 4'b0001);
        end
        cyc(1);
        chk("R2 bank1 released", 4'b0011);
    endtask

    task automatic t_strobe(input bit use_cancel);
        string tag;
        tag = use_cancel ? "R5" : "R4";
        clear_all();
        k = 8'd2;
        ready = 4'b1100;
        cyc(2);
        chk(tag, 4'b1100);
        if (use_cancel) cancel = 4'b0100; else arrive = 4'b0100;
        chk(tag, 4'b1000);
        cyc(1);
        arrive = '0; cancel = '0;
        chk(tag, 4'b1000);
        cyc(1);
        chk(tag, 4'b1000);
        cyc(1);
        chk(tag, 4'b1100);
    endtask

    task automatic t_saturate();
        clear_all();
        k = 8'd255;
        ready = 4'b0001;
        for (int j = 1; j <= 300; j++) begin
            cyc(1);
            if (j == 254) chk("R6 one before 255", 4'b0000);
            if (j == 255) chk("R6 at 255", 4'b0001);
            if (j == 256) chk("R6 no wrap past 255", 4'b0001);
            if (j == 300) chk("R6 still saturated", 4'b0001);
        end
    endtask

    task automatic t_k_zero();
        clear_all();
        k = 8'd0;
        ready = 4'b0010;
        chk("R7 k=0 immediate", 4'b0010);
    endtask

    task automatic t_idle();
        clear_all();
        k = 8'd100;
        rq_empty = 1'b1;
        ready = 4'b1010;
        set_pend(1, 1);
        arrive = 4'b1000;
        chk("R8 read queue empty", 4'b0010);
        cyc(1);
        arrive = '0;
        chk("R8 read queue empty, no arrival", 4'b1010);
    endtask

    task automatic t_forced();
        clear_all();
        k = 8'd100;
        hi_mark = 5'd20;
        occ = 5'd20;
        ready = 4'b1111;
        set_pend(0, 3);
        arrive = 4'b0010;
        cancel = 4'b0100;
        chk("R9 watermark reached", 4'b1111);
        cyc(1);
        occ = 5'd19;
        chk("R9 one below watermark", 4'b0000);
        hi_mark = 5'd0;
        ready = 4'b0101;
        chk("R9 watermark zero", 4'b0101);
    endtask

    task automatic t_ready_drop();
        clear_all();
        k = 8'd2;
        ready = 4'b0001;
        cyc(2);
        chk("R10 granted", 4'b0001);
        ready = 4'b0000;
        chk("R10 no ready no grant", 4'b0000);
        cyc(1);
        ready = 4'b0001;
        chk("R10 restart cycle 0", 4'b0000);
        cyc(1);
        chk("R10 restart cycle 1", 4'b0000);
        cyc(1);
        chk("R10 restart cycle 2", 4'b0001);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_pending();
        t_strobe(1'b0);
        t_strobe(1'b1);
        t_saturate();
        t_k_zero();
        t_idle();
        t_forced();
        t_ready_drop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule